// File: doc/BRIEF.md
# Dual Match-Compare Event Timer

The block holds two independent up-counting channels, each with a control word, a writable count and a match value. Software arms a one-shot event on a channel with four writes: it stops the channel, loads its count, loads its match value and starts it again. When the count of a running channel reaches the match value on a count step, the channel's flag in a shared status word is set. The channel's interrupt line is asserted while that flag is set and the channel's interrupt enable is on. Software acknowledges the event by writing a one to the flag.

Each channel is driven by a small state machine with two states, `CH_STOP` and `CH_RUN`. The transition `STOP_TO_RUN` is taken on the first clock after the count-enable bit is seen set. The transition `RUN_TO_STOP` is taken on the first clock after the bit is seen clear. In `CH_RUN` with the enable still set, a prescale counter divides the clock by (P+1). Each division step advances the count by one and evaluates the compare. The count wraps modulo 2^32 and keeps running after a match.

Top module: `dual_event_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: Register map (byte address): control ch0 0x00, ch1 0x04; match ch0 0x18, ch1 0x1C; count ch0 0x48, ch1 0x4C; status 0x60. Control bits are: bit0 count enable, bit1 interrupt enable, bit2 spare mode bit, bits[15:8] prescale P. Other control bits read 0. Unmapped addresses read 0. Written fields read back.
- R3: While a channel is running, its count advances by exactly one every (P+1) clocks and wraps from 0xFFFFFFFF to 0. P=0 advances it on every clock.
- R4: Let the final control write that sets bit0 land on clock edge E0, with d = (match − start) mod 2^32. The channel's status bit stays 0 through edge E(L−1) and is 1 after edge EL, where L = (d+1)(P+1)+1.
- R5: After a match the count keeps incrementing, and the status bit does not set again while the count moves away from the match value.
- R6: Writing 1 to status bit N (bit0 = ch0, bit1 = ch1) clears only that bit. Writing 0 leaves it unchanged.
- R7: If a clear of status bit N and a new match on channel N happen on the same edge, the bit stays set.
- R8: Interrupt output N is high exactly when status bit N and control bit1 of channel N are both 1.
- R9: Clearing control bit0 freezes the count on the next clock, and no further match occurs.
- R10: A write to a count register takes effect on that edge, even while the channel runs. Counting then continues from the written value.
- R11: Control bit2 is read/write and has no effect on count rate or match timing.
- R12: Activity on one channel never changes the other channel's count or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 2 | Per-channel interrupt lines, bit N for channel N |

## Verification
The assertions assume one register access per clock, with bus_wen high for a single edge per write and bus_addr stable around that edge. They also assume that software does not lower the prescale value below the prescale counter's current position during a run. The stimulus writes only through a task that raises bus_wen on a falling edge for exactly one rising edge. It reprograms the prescaler only while the channel is stopped, and it samples status after the computed latency. A match table walks both channels through short deltas, prescale values, the spare mode bit, a masked interrupt and a count wrap. Directed sequences then cover the clear/match collision, restart by count write, stop and cross-channel clears.

// File: rtl/det_pkg.sv
package det_pkg;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned CH_STRIDE  = 4;
    localparam int unsigned PRE_LSB    = 8;
    localparam logic [7:0]  OFS_CTRL   = 8'h00;
    localparam logic [7:0]  OFS_MATCH  = 8'h18;
    localparam logic [7:0]  OFS_COUNT  = 8'h48;
    localparam logic [7:0]  OFS_STATUS = 8'h60;

    typedef enum logic [0:0] {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/det_regif.sv
module det_regif
    import det_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wen,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_word,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  match_val,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_val,
    input  logic [NUM_CH-1:0]             stat_val,
    output logic [NUM_CH-1:0]             ctrl_we,
    output logic [NUM_CH-1:0]             match_we,
    output logic [NUM_CH-1:0]             cnt_we,
    output logic                          stat_we,
    output logic [DATA_W-1:0]             rdata
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_dec
            localparam logic [ADDR_W-1:0] A_CTRL  = OFS_CTRL  + ADDR_W'(g * CH_STRIDE);
            localparam logic [ADDR_W-1:0] A_MATCH = OFS_MATCH + ADDR_W'(g * CH_STRIDE);
            localparam logic [ADDR_W-1:0] A_COUNT = OFS_COUNT + ADDR_W'(g * CH_STRIDE);
            assign ctrl_we[g]  = wen && (addr == A_CTRL);
            assign match_we[g] = wen && (addr == A_MATCH);
            assign cnt_we[g]   = wen && (addr == A_COUNT);
        end
    endgenerate

    assign stat_we = wen && (addr == OFS_STATUS);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == OFS_CTRL + ADDR_W'(i * CH_STRIDE))
                rdata = ctrl_word[i];
            if (addr == OFS_MATCH + ADDR_W'(i * CH_STRIDE))
                rdata = DATA_W'(match_val[i]);
            if (addr == OFS_COUNT + ADDR_W'(i * CH_STRIDE))
                rdata = DATA_W'(cnt_val[i]);
        end
        if (addr == OFS_STATUS)
            rdata = DATA_W'(stat_val);
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, match_we, cnt_we, stat_we})); // R2
endmodule

// File: rtl/det_channel.sv
module det_channel
    import det_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              match_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_o,
    output logic              ien_o,
    output logic              mode_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic [CNT_W-1:0]  match_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              match_evt_o
);
    logic             en_q, ien_q, mode_q;
    logic [PRE_W-1:0] pre_q, pre_cnt_q;
    logic [CNT_W-1:0] cnt_q, match_q;
    ch_state_e        state_q, state_d;
    logic             run, tick;

    // control and match registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ien_q   <= 1'b0;
            mode_q  <= 1'b0;
            pre_q   <= '0;
            match_q <= '0;
        end else begin
            if (ctrl_we) begin
                en_q   <= wdata[0];
                ien_q  <= wdata[1];
                mode_q <= wdata[2];
                pre_q  <= wdata[PRE_LSB +: PRE_W];
            end
            if (match_we)
                match_q <= wdata[CNT_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    // next state: STOP_TO_RUN and RUN_TO_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: if (en_q)  state_d = CH_RUN;
            CH_RUN:  if (!en_q) state_d = CH_STOP;
            default:            state_d = CH_STOP;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run         = (state_q == CH_RUN) && en_q;
        tick        = run && (pre_cnt_q >= pre_q);
        match_evt_o = tick && !cnt_we && (cnt_q == match_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_cnt_q <= '0;
        else if (!run || cnt_we)    pre_cnt_q <= '0;
        else if (tick)              pre_cnt_q <= '0;
        else                        pre_cnt_q <= pre_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_we)  cnt_q <= wdata[CNT_W-1:0];
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    assign en_o    = en_q;
    assign ien_o   = ien_q;
    assign mode_o  = mode_q;
    assign pre_o   = pre_q;
    assign match_o = match_q;
    assign cnt_o   = cnt_q;

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_we) |=> $stable(cnt_q)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wdata[CNT_W-1:0]))); // R10
    AST_ARM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> !tick); // R4
endmodule

// File: rtl/det_status.sv
module det_status #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] match_evt,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] ien,
    output logic [NUM_CH-1:0] stat,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] stat_q, stat_d, clr_mask;

    assign clr_mask = clr_we ? wdata[NUM_CH-1:0] : '0;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            stat_d[i] = match_evt[i] | (stat_q[i] & ~clr_mask[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
    assign irq  = stat_q & ien;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                match_evt[g] |=> stat_q[g]); // R7
            AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && wdata[g] && !match_evt[g]) |=> !stat_q[g]); // R6
            AST_NO_FALSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_q[g] && !match_evt[g]) |=> !stat_q[g]); // R4
        end
    endgenerate
endmodule

// File: rtl/dual_event_timer.sv
module dual_event_timer
    import det_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq_out
);
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_word;
    logic [NUM_CH-1:0][CNT_W-1:0]  match_val, cnt_val;
    logic [NUM_CH-1:0]             ctrl_we, match_we, cnt_we;
    logic [NUM_CH-1:0]             en, ien, mode, evt, stat;
    logic [NUM_CH-1:0][PRE_W-1:0]  pre;
    logic                          stat_we;

    det_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (bus_wen),
        .addr     (bus_addr),
        .ctrl_word(ctrl_word),
        .match_val(match_val),
        .cnt_val  (cnt_val),
        .stat_val (stat),
        .ctrl_we  (ctrl_we),
        .match_we (match_we),
        .cnt_we   (cnt_we),
        .stat_we  (stat_we),
        .rdata    (bus_rdata)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            det_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .ctrl_we    (ctrl_we[g]),
                .match_we   (match_we[g]),
                .cnt_we     (cnt_we[g]),
                .wdata      (bus_wdata),
                .en_o       (en[g]),
                .ien_o      (ien[g]),
                .mode_o     (mode[g]),
                .pre_o      (pre[g]),
                .match_o    (match_val[g]),
                .cnt_o      (cnt_val[g]),
                .match_evt_o(evt[g])
            );
            assign ctrl_word[g] = DATA_W'({pre[g], 5'b00000, mode[g], ien[g], en[g]});
        end
    endgenerate

    det_status #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_evt(evt),
        .clr_we   (stat_we),
        .wdata    (bus_wdata),
        .ien      (ien),
        .stat     (stat),
        .irq      (irq_out)
    );
endmodule

// File: tb/dual_event_timer_test.sv
`timescale 1ns/1ps
module dual_event_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_event_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    localparam int NV = 7;
    localparam logic        V_CH    [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [31:0] V_START [NV] = '{32'd0, 32'd0, 32'd10, 32'hFFFF_FFFE, 32'd0, 32'd7, 32'd3};
    localparam logic [31:0] V_MATCH [NV] = '{32'd2, 32'd5, 32'd20, 32'd1, 32'd4, 32'd9, 32'd6};
    localparam logic [31:0] V_CTRL  [NV] = '{32'h003, 32'h003, 32'h203, 32'h003, 32'h007, 32'h001, 32'h103};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm(input int ch, input logic [31:0] st, input logic [31:0] mt, input logic [31:0] c);
        wr(8'h00 + 8'(ch * 4), 32'h0);
        wr(8'h48 + 8'(ch * 4), st);
        wr(8'h18 + 8'(ch * 4), mt);
        wr(8'h00 + 8'(ch * 4), c);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        foreach (V_CTRL[k]) begin end
        begin
            logic [7:0] addrs [7] = '{8'h00, 8'h04, 8'h18, 8'h1C, 8'h48, 8'h4C, 8'h60};
            for (int i = 0; i < 7; i++) begin
                rd(addrs[i], d);
                check("R1 reg", d, 32'h0);
            end
        end
        check("R1 irq", {30'h0, irq_out}, 32'h0);

        // R2: readback of fields
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h04, d); check("R2 ctrl mask", d, 32'h0000_FF06);
        wr(8'h1C, 32'hDEAD_BEEF);
        rd(8'h1C, d); check("R2 match", d, 32'hDEAD_BEEF);
        rd(8'h10, d); check("R2 unmapped", d, 32'h0);
        wr(8'h04, 32'h0);

        // table of match vectors: R4 R8 R11 R12 R3 (wrap, prescale)
        for (int i = 0; i < NV; i++) begin
            int ch;
            logic [31:0] dd;
            int p, lat;
            ch  = int'(V_CH[i]);
            dd  = V_MATCH[i] - V_START[i];
            p   = int'(V_CTRL[i][15:8]);
            lat = (int'(dd) + 1) * (p + 1) + 1;
            arm(ch, V_START[i], V_MATCH[i], V_CTRL[i]);
            repeat (lat - 1) @(negedge clk);
            rd(8'h60, d);
            check("R4 before match", d, 32'h0);
            @(negedge clk);
            rd(8'h60, d);
            check("R4 R12 R11 status at match", d, 32'(1 << ch));
            check("R8 irq gating", {30'h0, irq_out}, V_CTRL[i][1] ? 32'(1 << ch) : 32'h0);
            wr(8'h60, 32'(1 << ch));
            rd(8'h60, d);
            check("R6 clear", d, 32'h0);
            wr(8'h00 + 8'(ch * 4), 32'h0);
        end

        // R3: prescale 2 rate
        arm(0, 32'h0, 32'hFFFF_FFFF, 32'h203);
        repeat (13) @(negedge clk);
        rd(8'h48, d); check("R3 count rate", d, 32'd4);

        // R9: stop freezes count
        wr(8'h00, 32'h0);
        rd(8'h48, c0);
        repeat (10) @(negedge clk);
        rd(8'h48, d); check("R9 frozen", d, c0);
        rd(8'h60, d); check("R9 no event", d, 32'h0);

        // R10: count write while running
        arm(1, 32'h0, 32'hFFFF_0000, 32'h003);
        repeat (5) @(negedge clk);
        wr(8'h4C, 32'd100);
        rd(8'h4C, d); check("R10 load", d, 32'd100);
        @(negedge clk);
        rd(8'h4C, d); check("R10 continue", d, 32'd101);
        wr(8'h04, 32'h0);

        // R5: no re-match after match
        arm(0, 32'h0, 32'd3, 32'h003);
        repeat (5) @(negedge clk);
        rd(8'h60, d); check("R5 first match", d, 32'h1);
        wr(8'h60, 32'h1);
        repeat (40) @(negedge clk);
        rd(8'h60, d); check("R5 no rematch", d, 32'h0);
        rd(8'h48, d); check("R5 still counting", {31'h0, d > 32'd3}, 32'h1);

        // R7: clear and match on the same edge
        arm(0, 32'h0, 32'd2, 32'h003);
        repeat (4) @(negedge clk);
        rd(8'h60, d); check("R7 preset", d, 32'h1);
        arm(0, 32'h0, 32'd2, 32'h003);
        repeat (2) @(negedge clk);
        wr(8'h60, 32'h1);
        rd(8'h60, d); check("R7 set wins", d, 32'h1);
        wr(8'h60, 32'h1);
        rd(8'h60, d); check("R7 later clear", d, 32'h0);
        wr(8'h00, 32'h0);

        // R6 R12: selective clear across channels
        arm(0, 32'h0, 32'd2, 32'h003);
        arm(1, 32'h0, 32'd2, 32'h003);
        repeat (6) @(negedge clk);
        rd(8'h60, d); check("R12 both set", d, 32'h3);
        wr(8'h60, 32'h2);
        rd(8'h60, d); check("R6 R12 clear ch1 only", d, 32'h1);
        wr(8'h60, 32'h0);
        rd(8'h60, d); check("R6 zero write", d, 32'h1);
        check("R8 irq ch0 only", {30'h0, irq_out}, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule